// File: doc/BRIEF.md
# Interrupt Admission Controller

This block sits beside a CPU pipeline and decides, cycle by cycle, whether a pending interrupt may be admitted. It handles three classes: a non-maskable class, a real-time class and an ordinary low-priority class. When more than one class is eligible in the same cycle, a fixed priority picks a single winner. The accept outputs are combinational from the request lines and the registered state. Admitting a class is treated as entry into its service routine.

Software can open an atomic section that runs for 1 to 256 instruction packets. During that section the real-time and ordinary classes are held off. The section counts down once per retired packet. A non-maskable request is still admitted during the section, and admitting it ends the section.

Ordinary interrupts are admitted only while the active stack matches the stack assigned to them. Taking a real-time or non-maskable interrupt switches the active stack to the dedicated real-time stack. Each class keeps a nesting depth, and its status flag stays raised until the last nested routine of that class has exited. A 32-bit status word exposes the link ID, both stack IDs, the atomic countdown, an atomic-active bit and the three class flags.

Top module: `irq_adm_ctrl`

## Requirements
- R1: At most one accept output is high in a cycle. Priority is non-maskable, then real-time, then ordinary.
- R2: A start with `atom_len_m1 = L` while idle opens a section of L+1 packets. The next cycle, status[15:8] reads remaining-1 and status[3] reads 1. Each `pkt_retire` lowers the remaining count by one, and the section ends after the last packet.
- R3: While status[3] is 1, `acc_rt` and `acc_int` stay low.
- R4: `nmi_req` is accepted during a section, and the next cycle status[15:8] and status[3] read 0.
- R5: A start pulse while a section is active has no effect on the countdown.
- R6: `acc_int` can be high only when `int_sid` equals the active stack ID in status[19:16].
- R7: The cycle after a non-maskable or real-time accept, status[19:16] equals `rt_sid`. Otherwise `sp_wr` loads `sp_wdata` into it. `sel_sid` gives `rt_sid` for those accepts and `int_sid` for an ordinary accept.
- R8: Flags are status[0] ordinary, status[1] real-time, status[2] non-maskable. A flag rises the cycle after its class is accepted. It falls only when `isr_exit` (bit 0 ordinary, bit 1 real-time, bit 2 non-maskable) has pulsed once for every nested accept.
- R9: An exit pulse for a class with depth zero is ignored. A later single accept then needs exactly one exit to clear the flag.
- R10: Nesting depth saturates at 15. After 16 accepts, 15 exits clear the flag.
- R11: After reset, status bits 19:0 are zero, status[31:24] mirrors `link_id` and status[23:20] mirrors `int_sid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request |
| rt_req | input | 1 | Real-time request |
| int_req | input | 1 | Ordinary request |
| pkt_retire | input | 1 | One instruction packet retired |
| atom_start | input | 1 | Open an atomic section |
| atom_len_m1 | input | 8 | Section length minus one |
| isr_exit | input | 3 | Routine exit pulses {nmi, rt, int} |
| int_sid | input | 4 | Stack ID assigned to ordinary interrupts |
| rt_sid | input | 4 | Dedicated real-time stack ID |
| sp_wr | input | 1 | Load the active stack ID |
| sp_wdata | input | 4 | Value for the active stack ID |
| link_id | input | 8 | Current link ID, shown in status |
| acc_nmi | output | 1 | Non-maskable accepted this cycle |
| acc_rt | output | 1 | Real-time accepted this cycle |
| acc_int | output | 1 | Ordinary accepted this cycle |
| sel_sid | output | 4 | Stack ID for the admitted interrupt, or the active one |
| status | output | 32 | Status word |

## Verification
The assertions assume that each `isr_exit` bit pulses for exactly one cycle per routine exit. They also assume that `rt_sid`, `int_sid` and the request lines are known, non-X values from reset onward. The stimulus meets these assumptions by changing inputs only on the falling edge and clearing every pulse after one cycle. It also holds the stack IDs steady through each scenario. A decrement check relies on `pkt_retire` arriving only while no accept cancels the section. Where the stimulus pairs a retire with a non-maskable accept, the assertion excludes that case explicitly.

// File: rtl/irq_adm_pkg.sv
package irq_adm_pkg;
    localparam int SID_W   = 4;
    localparam int LINK_W  = 8;
    localparam int LEN_W   = 8;
    localparam int DEP_W   = 4;
    localparam int DEP_MAX = 15;
    localparam int NCLS    = 3;
    localparam int ST_W    = LINK_W + 2 * SID_W + LEN_W + 8;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_RT  = 2'd1,
        CLS_NMI = 2'd2
    } irq_cls_e;

    typedef struct packed {
        logic [LEN_W:0] rem;
    } atom_st_t;

    typedef struct packed {
        logic [DEP_W-1:0] depth;
    } nest_st_t;

    typedef struct packed {
        logic [SID_W-1:0] cur_sid;
    } stk_st_t;
endpackage

// File: rtl/irq_adm_atomic.sv
module irq_adm_atomic
    import irq_adm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             retire,
    input  logic             cancel,
    output logic             busy,
    output logic [LEN_W-1:0] field
);
    localparam logic [LEN_W:0]   ONE_W = {{LEN_W{1'b0}}, 1'b1};
    localparam logic [LEN_W-1:0] ONE_F = {{(LEN_W-1){1'b0}}, 1'b1};

    atom_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cancel) begin
            st_d.rem = '0;
        end else if (st_q.rem != '0) begin
            if (retire) begin
                st_d.rem = st_q.rem - ONE_W;
            end
        end else if (start) begin
            st_d.rem = {1'b0, len_m1} + ONE_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = (st_q.rem != '0);
    assign field = busy ? (st_q.rem[LEN_W-1:0] - ONE_F) : '0;
endmodule

// File: rtl/irq_adm_nest.sv
module irq_adm_nest
    import irq_adm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic leave,
    output logic active
);
    localparam logic [DEP_W-1:0] DEP_TOP = DEP_W'(DEP_MAX);
    localparam logic [DEP_W-1:0] ONE_D   = {{(DEP_W-1){1'b0}}, 1'b1};

    nest_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (leave && st_q.depth != '0) begin
            st_d.depth = st_d.depth - ONE_D;
        end
        if (take && st_d.depth != DEP_TOP) begin
            st_d.depth = st_d.depth + ONE_D;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.depth != '0);
endmodule

// File: rtl/irq_adm_arb.sv
module irq_adm_arb (
    input  logic nmi_req,
    input  logic rt_req,
    input  logic int_req,
    input  logic hold,
    input  logic sid_match,
    output logic acc_nmi,
    output logic acc_rt,
    output logic acc_int
);
    logic rt_ok, int_ok;

    always_comb begin
        rt_ok   = rt_req && !hold;
        int_ok  = int_req && !hold && sid_match;
        acc_nmi = nmi_req;
        acc_rt  = rt_ok && !nmi_req;
        acc_int = int_ok && !nmi_req && !rt_ok;
    end
endmodule

// File: rtl/irq_adm_ctrl.sv
module irq_adm_ctrl
    import irq_adm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nmi_req,
    input  logic                rt_req,
    input  logic                int_req,
    input  logic                pkt_retire,
    input  logic                atom_start,
    input  logic [LEN_W-1:0]    atom_len_m1,
    input  logic [NCLS-1:0]     isr_exit,
    input  logic [SID_W-1:0]    int_sid,
    input  logic [SID_W-1:0]    rt_sid,
    input  logic                sp_wr,
    input  logic [SID_W-1:0]    sp_wdata,
    input  logic [LINK_W-1:0]   link_id,
    output logic                acc_nmi,
    output logic                acc_rt,
    output logic                acc_int,
    output logic [SID_W-1:0]    sel_sid,
    output logic [ST_W-1:0]     status
);
    stk_st_t          st_d, st_q;
    logic             atom_busy;
    logic [LEN_W-1:0] atom_field;
    logic             sid_match;
    logic [NCLS-1:0]  acc_vec;
    logic [NCLS-1:0]  flags;

    assign sid_match = (int_sid == st_q.cur_sid);

    irq_adm_arb arb_i (
        .nmi_req   (nmi_req),
        .rt_req    (rt_req),
        .int_req   (int_req),
        .hold      (atom_busy),
        .sid_match (sid_match),
        .acc_nmi   (acc_nmi),
        .acc_rt    (acc_rt),
        .acc_int   (acc_int)
    );

    irq_adm_atomic atom_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (atom_start),
        .len_m1 (atom_len_m1),
        .retire (pkt_retire),
        .cancel (acc_nmi),
        .busy   (atom_busy),
        .field  (atom_field)
    );

    always_comb begin
        acc_vec = '0;
        acc_vec[CLS_INT] = acc_int;
        acc_vec[CLS_RT]  = acc_rt;
        acc_vec[CLS_NMI] = acc_nmi;
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_nest
        irq_adm_nest nest_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (acc_vec[c]),
            .leave  (isr_exit[c]),
            .active (flags[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (acc_nmi || acc_rt) begin
            st_d.cur_sid = rt_sid;
        end else if (sp_wr) begin
            st_d.cur_sid = sp_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (acc_nmi || acc_rt) begin
            sel_sid = rt_sid;
        end else if (acc_int) begin
            sel_sid = int_sid;
        end else begin
            sel_sid = st_q.cur_sid;
        end
    end

    assign status = {link_id, int_sid, st_q.cur_sid, atom_field,
                     {(8 - NCLS - 1){1'b0}}, atom_busy, flags};
endmodule

// File: rtl/irq_adm_chk.sv
module irq_adm_chk
    import irq_adm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             acc_nmi,
    input logic             acc_rt,
    input logic             acc_int,
    input logic             pkt_retire,
    input logic [NCLS-1:0]  isr_exit,
    input logic [SID_W-1:0] int_sid,
    input logic [SID_W-1:0] rt_sid,
    input logic [ST_W-1:0]  status
);
    localparam int CUR_LO = LEN_W + 8;
    localparam int FLD_LO = 8;
    localparam int BSY    = 3;

    logic [SID_W-1:0] cur_f;
    logic [LEN_W-1:0] fld_f;
    assign cur_f = status[CUR_LO +: SID_W];
    assign fld_f = status[FLD_LO +: LEN_W];

    a_r1_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_nmi, acc_rt, acc_int}));

    a_r3_atomic_hold: assert property (@(posedge clk) disable iff (!rst_n)
        status[BSY] |-> (!acc_rt && !acc_int));

    a_r4_nmi_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        acc_nmi |=> (fld_f == '0 && !status[BSY]));

    a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BSY] && pkt_retire && !acc_nmi && fld_f != '0)
        |=> (fld_f == $past(fld_f) - 1'b1));

    a_r6_stack_match: assert property (@(posedge clk) disable iff (!rst_n)
        acc_int |-> (int_sid == cur_f));

    a_r7_rt_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_nmi || acc_rt) |=> (cur_f == $past(rt_sid)));

    a_r8_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        acc_int |=> status[0]);

    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_exit[0] && !status[0] && !acc_int) |=> !status[0]);
endmodule

bind irq_adm_ctrl irq_adm_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_nmi    (acc_nmi),
    .acc_rt     (acc_rt),
    .acc_int    (acc_int),
    .pkt_retire (pkt_retire),
    .isr_exit   (isr_exit),
    .int_sid    (int_sid),
    .rt_sid     (rt_sid),
    .status     (status)
);

// File: tb/irq_adm_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_adm_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 0, rt_req = 0, int_req = 0;
    logic        pkt_retire = 0, atom_start = 0;
    logic [7:0]  atom_len_m1 = '0;
    logic [2:0]  isr_exit = '0;
    logic [3:0]  int_sid = 4'h3, rt_sid = 4'hE;
    logic        sp_wr = 0;
    logic [3:0]  sp_wdata = '0;
    logic [7:0]  link_id = 8'hA5;
    logic        acc_nmi, acc_rt, acc_int;
    logic [3:0]  sel_sid;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_status;
        logic [31:0] exp;
        logic [31:0] mask;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    irq_adm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .rt_req(rt_req),
        .int_req(int_req), .pkt_retire(pkt_retire), .atom_start(atom_start),
        .atom_len_m1(atom_len_m1), .isr_exit(isr_exit), .int_sid(int_sid),
        .rt_sid(rt_sid), .sp_wr(sp_wr), .sp_wdata(sp_wdata), .link_id(link_id),
        .acc_nmi(acc_nmi), .acc_rt(acc_rt), .acc_int(acc_int),
        .sel_sid(sel_sid), .status(status)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        nmi_req = 0; rt_req = 0; int_req = 0; pkt_retire = 0;
        atom_start = 0; isr_exit = '0; sp_wr = 0;
    endtask

    // acc view: {sel_sid, 1'b0, acc_nmi, acc_rt, acc_int}
    task automatic push_acc(logic [31:0] e, logic [31:0] m, string r);
        item_t it;
        it.is_status = 0; it.exp = e; it.mask = m; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic push_st(logic [31:0] e, logic [31:0] m, string r);
        item_t it;
        it.is_status = 1; it.exp = e; it.mask = m; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic set_stack3();
        sp_wr = 1; sp_wdata = 4'h3; tick(); idle();
    endtask

    // monitor: compares queued expectations a little after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] obs;
                it = sb_q.pop_front();
                obs = it.is_status ? status
                                   : {24'b0, sel_sid, 1'b0, acc_nmi, acc_rt, acc_int};
                checks++;
                if ((obs & it.mask) !== (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h (mask %h)",
                             it.req, obs & it.mask, it.exp & it.mask, it.mask);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        push_st(32'hA530_0000, 32'hFFFF_FFFF, "R11");
        push_acc(0, 32'h7, "R11");
        tick();

        // R6: stack mismatch holds off ordinary interrupt
        int_req = 1; push_acc(0, 32'h7, "R6"); tick(); idle();
        sp_wr = 1; sp_wdata = 4'h3; tick(); idle();
        push_st(32'h0003_0000, 32'h000F_0000, "R7");
        int_req = 1; push_acc(32'h31, 32'hF7, "R6"); tick(); idle();
        push_st(32'h1, 32'h7, "R8");
        isr_exit = 3'b001; tick(); idle();
        push_st(32'h0, 32'h7, "R8");

        // R1: all three at once
        nmi_req = 1; rt_req = 1; int_req = 1;
        push_acc(32'hE4, 32'hF7, "R1"); tick(); idle();
        push_st(32'h000E_0004, 32'h000F_0007, "R7");
        isr_exit = 3'b100; tick(); idle();
        push_st(32'h0, 32'h7, "R8");
        set_stack3();
        rt_req = 1; int_req = 1;
        push_acc(32'hE2, 32'hF7, "R1"); tick(); idle();
        push_st(32'h000E_0002, 32'h000F_0007, "R7");
        isr_exit = 3'b010; tick(); idle();
        set_stack3();

        // R2/R3/R5/R4: atomic section interrupted by NMI
        atom_start = 1; atom_len_m1 = 8'd4; tick(); idle();
        push_st(32'h0408, 32'hFF08, "R2");
        rt_req = 1; int_req = 1; pkt_retire = 1;
        push_acc(0, 32'h7, "R3"); tick(); idle();
        push_st(32'h0308, 32'hFF08, "R2");
        atom_start = 1; atom_len_m1 = 8'd200; tick(); idle();
        push_st(32'h0308, 32'hFF08, "R5");
        pkt_retire = 1; tick(); idle();
        push_st(32'h0208, 32'hFF08, "R2");
        nmi_req = 1; rt_req = 1;
        push_acc(32'hE4, 32'hF7, "R4"); tick(); idle();
        push_st(32'h0004, 32'hFF0F, "R4");
        isr_exit = 3'b100; tick(); idle();
        set_stack3();

        // R2: single-packet section, expiry releases INT
        atom_start = 1; atom_len_m1 = 8'd0; tick(); idle();
        push_st(32'h0008, 32'hFF08, "R2");
        int_req = 1; push_acc(0, 32'h7, "R3"); tick(); idle();
        int_req = 1; pkt_retire = 1; push_acc(0, 32'h7, "R3"); tick(); idle();
        push_st(32'h0, 32'hFF08, "R2");
        int_req = 1; push_acc(32'h31, 32'hF7, "R3"); tick(); idle();
        isr_exit = 3'b001; tick(); idle();

        // R2: full 256-packet section
        atom_start = 1; atom_len_m1 = 8'd255; tick(); idle();
        push_st(32'hFF08, 32'hFF08, "R2");
        for (int i = 0; i < 255; i++) begin
            pkt_retire = 1; tick();
        end
        idle();
        push_st(32'h0008, 32'hFF08, "R2");
        pkt_retire = 1; tick(); idle();
        push_st(32'h0, 32'hFF08, "R2");

        // R8: three-deep nest of ordinary interrupts
        for (int i = 0; i < 3; i++) begin
            int_req = 1; push_acc(32'h31, 32'hF7, "R8"); tick();
        end
        idle();
        push_st(32'h1, 32'h7, "R8");
        isr_exit = 3'b001; tick(); idle(); push_st(32'h1, 32'h7, "R8");
        isr_exit = 3'b001; tick(); idle(); push_st(32'h1, 32'h7, "R8");
        isr_exit = 3'b001; tick(); idle(); push_st(32'h0, 32'h7, "R8");

        // R9: exits at depth zero are ignored
        isr_exit = 3'b001; tick(); idle();
        isr_exit = 3'b001; tick(); idle();
        push_st(32'h0, 32'h7, "R9");
        int_req = 1; tick(); idle();
        push_st(32'h1, 32'h7, "R9");
        isr_exit = 3'b001; tick(); idle();
        push_st(32'h0, 32'h7, "R9");

        // R10: depth saturation at 15
        for (int i = 0; i < 16; i++) begin
            rt_req = 1; tick();
        end
        idle();
        for (int i = 0; i < 14; i++) begin
            isr_exit = 3'b010; tick();
        end
        idle();
        push_st(32'h2, 32'h2, "R10");
        isr_exit = 3'b010; tick(); idle();
        push_st(32'h0, 32'h2, "R10");

        tick();
        tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule